// File: doc/BRIEF.md
# Paced Pattern Pin Driver

This block turns a stream of pattern words into drive controls for a bank of bidirectional pins. Words arrive on a valid/ready interface. A programmable rate divider paces the stream: one word is taken every (divider + 1) clock cycles, and the current word is held on the pins until the next one is taken. If a slot comes and no word is offered, the last word stays on the pins and a one-cycle underflow flag is raised.

Before the pins, each bit passes through three per-pin controls. An override mask selects a software-supplied override value in place of the pattern bit. A direction mask turns a pin into an input, which is never driven. A global mode bit selects push-pull or open-drain drive. The result is presented as an output-enable and an output-value per pin, ready for an external I/O buffer. All configuration ports are captured into internal registers that reset to zero, so a change on a configuration port reaches the pins one clock later.

Top module: `pgd_pin_driver`

## Requirements
- R1: `pat_ready` is high on the first cycle after reset and then once every (divider + 1) cycles. A word offered with `pat_valid` high is accepted in a cycle where `pat_ready` is high, so a continuously offered stream is accepted exactly every (divider + 1) cycles.
- R2: The held pattern word changes only on a clock edge where `pat_valid` and `pat_ready` are both high. Between acceptances, the pins keep the last accepted word.
- R3: If `pat_ready` is high and `pat_valid` is low, the held word is kept and `underflow` is high for exactly the following cycle. In every other cycle, `underflow` is low.
- R4: A pin whose direction bit is 1 is an input. Its `pin_oe` and `pin_val` bits are 0, whatever its override mask bit or the drive mode. A direction bit of 0 makes the pin an output.
- R5: A pin whose override mask bit is 1 takes its source bit from the same bit of the override data. A mask bit of 0 takes the source bit from the held pattern word.
- R6: In push-pull mode (mode bit 0), an output pin has `pin_oe` = 1 and `pin_val` = its source bit.
- R7: In open-drain mode (mode bit 1), an output pin with source bit 0 has `pin_oe` = 1 and `pin_val` = 0. An output pin with source bit 1 has `pin_oe` = 0 and `pin_val` = 0.
- R8: While reset is held, and afterwards until the configuration is changed, the internal configuration and the held word are zero. All pins are then push-pull outputs driving 0: `pin_oe` is all ones and `pin_val` is 0. `underflow` is low during reset.
- R9: A change on any configuration port is captured at the next clock edge. It is seen at the pins only after that edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_div | input | 32 | Rate divider: one word taken every cfg_div + 1 cycles |
| cfg_dir | input | 16 | Per-pin direction, 1 = input, 0 = output |
| cfg_ovr_mask | input | 16 | Per-pin override select, 1 = use cfg_ovr_data |
| cfg_ovr_data | input | 16 | Per-pin override value |
| cfg_open_drain | input | 1 | Drive mode, 0 = push-pull, 1 = open-drain |
| pat_valid | input | 1 | A pattern word is offered |
| pat_ready | output | 1 | Slot open, the offered word is taken this cycle |
| pat_data | input | 16 | Offered pattern word |
| pin_oe | output | 16 | Per-pin output enable |
| pin_val | output | 16 | Per-pin output value |
| underflow | output | 1 | One-cycle flag: the previous slot found no word |

## Verification
The hardest situation to reach is the exact acceptance spacing of R1. It is visible only when the source offers words without a break and the counter has already been reloaded with the new divider value. The driver therefore keeps `pat_valid` high across back-to-back words, and after each divider change it waits idle for several slots before starting a burst. The monitor then measures the cycles between consecutive handshakes in the burst. Underflow is reached by leaving the stream idle and counting flags over a window of whole divider periods.

// File: rtl/pgd_pkg.sv
package pgd_pkg;

    typedef enum logic {
        DRV_PUSH_PULL  = 1'b0,
        DRV_OPEN_DRAIN = 1'b1
    } drive_mode_e;

endpackage

// File: rtl/pgd_cfg_regs.sv
module pgd_cfg_regs
    import pgd_pkg::*;
#(
    parameter int PINS  = 16,
    parameter int DIV_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic [PINS-1:0]  dir_i,
    input  logic [PINS-1:0]  ovr_mask_i,
    input  logic [PINS-1:0]  ovr_data_i,
    input  logic             open_drain_i,
    output logic [DIV_W-1:0] div_o,
    output logic [PINS-1:0]  dir_o,
    output logic [PINS-1:0]  ovr_mask_o,
    output logic [PINS-1:0]  ovr_data_o,
    output drive_mode_e      mode_o
);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [PINS-1:0]  dir;
        logic [PINS-1:0]  ovr_mask;
        logic [PINS-1:0]  ovr_data;
        drive_mode_e      mode;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d          = cfg_q;
        cfg_d.div      = div_i;
        cfg_d.dir      = dir_i;
        cfg_d.ovr_mask = ovr_mask_i;
        cfg_d.ovr_data = ovr_data_i;
        cfg_d.mode     = drive_mode_e'(open_drain_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign div_o      = cfg_q.div;
    assign dir_o      = cfg_q.dir;
    assign ovr_mask_o = cfg_q.ovr_mask;
    assign ovr_data_o = cfg_q.ovr_data;
    assign mode_o     = cfg_q.mode;

endmodule

// File: rtl/pgd_pacer.sv
module pgd_pacer #(
    parameter int DIV_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic             valid_i,
    output logic             slot_o,
    output logic             underflow_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             uflow;
    } pace_t;

    pace_t st_d, st_q;
    logic  slot;

    always_comb begin
        st_d = st_q;
        slot = (st_q.cnt == '0);
        if (slot) begin
            st_d.cnt   = div_i;
            st_d.uflow = !valid_i;
        end else begin
            st_d.cnt   = st_q.cnt - 1'b1;
            st_d.uflow = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot_o      = slot;
    assign underflow_o = st_q.uflow;

endmodule

// File: rtl/pgd_word_hold.sv
module pgd_word_hold #(
    parameter int PINS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take_i,
    input  logic [PINS-1:0] data_i,
    output logic [PINS-1:0] word_o
);

    logic [PINS-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (take_i) begin
            word_d = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign word_o = word_q;

endmodule

// File: rtl/pgd_pin_cell.sv
module pgd_pin_cell
    import pgd_pkg::*;
(
    input  logic        word_bit_i,
    input  logic        is_input_i,
    input  logic        ovr_sel_i,
    input  logic        ovr_bit_i,
    input  drive_mode_e mode_i,
    output logic        oe_o,
    output logic        val_o
);

    logic src;

    always_comb begin
        src   = ovr_sel_i ? ovr_bit_i : word_bit_i;
        oe_o  = 1'b0;
        val_o = 1'b0;
        if (!is_input_i) begin
            unique case (mode_i)
                DRV_PUSH_PULL: begin
                    oe_o  = 1'b1;
                    val_o = src;
                end
                DRV_OPEN_DRAIN: begin
                    oe_o  = !src;
                    val_o = 1'b0;
                end
                default: begin
                    oe_o  = 1'b0;
                    val_o = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/pgd_pin_driver.sv
module pgd_pin_driver
    import pgd_pkg::*;
#(
    parameter int PINS  = 16,
    parameter int DIV_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [PINS-1:0]  cfg_dir,
    input  logic [PINS-1:0]  cfg_ovr_mask,
    input  logic [PINS-1:0]  cfg_ovr_data,
    input  logic             cfg_open_drain,
    input  logic             pat_valid,
    output logic             pat_ready,
    input  logic [PINS-1:0]  pat_data,
    output logic [PINS-1:0]  pin_oe,
    output logic [PINS-1:0]  pin_val,
    output logic             underflow
);

    logic [DIV_W-1:0] div_q;
    logic [PINS-1:0]  dir_q;
    logic [PINS-1:0]  ovr_mask_q;
    logic [PINS-1:0]  ovr_data_q;
    drive_mode_e      mode_q;
    logic             slot;
    logic [PINS-1:0]  word_q;

    pgd_cfg_regs #(
        .PINS  (PINS),
        .DIV_W (DIV_W)
    ) i_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .div_i        (cfg_div),
        .dir_i        (cfg_dir),
        .ovr_mask_i   (cfg_ovr_mask),
        .ovr_data_i   (cfg_ovr_data),
        .open_drain_i (cfg_open_drain),
        .div_o        (div_q),
        .dir_o        (dir_q),
        .ovr_mask_o   (ovr_mask_q),
        .ovr_data_o   (ovr_data_q),
        .mode_o       (mode_q)
    );

    pgd_pacer #(
        .DIV_W (DIV_W)
    ) i_pacer (
        .clk         (clk),
        .rst_n       (rst_n),
        .div_i       (div_q),
        .valid_i     (pat_valid),
        .slot_o      (slot),
        .underflow_o (underflow)
    );

    pgd_word_hold #(
        .PINS (PINS)
    ) i_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_i (slot && pat_valid),
        .data_i (pat_data),
        .word_o (word_q)
    );

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        pgd_pin_cell i_cell (
            .word_bit_i (word_q[p]),
            .is_input_i (dir_q[p]),
            .ovr_sel_i  (ovr_mask_q[p]),
            .ovr_bit_i  (ovr_data_q[p]),
            .mode_i     (mode_q),
            .oe_o       (pin_oe[p]),
            .val_o      (pin_val[p])
        );
    end

    assign pat_ready = slot;

endmodule

// File: rtl/pgd_pin_driver_chk.sv
module pgd_pin_driver_chk
    import pgd_pkg::*;
#(
    parameter int PINS  = 16,
    parameter int DIV_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pat_valid,
    input logic             pat_ready,
    input logic             underflow,
    input logic [PINS-1:0]  pin_oe,
    input logic [PINS-1:0]  pin_val,
    input logic [PINS-1:0]  word_q,
    input logic [PINS-1:0]  dir_q,
    input logic [DIV_W-1:0] div_q,
    input drive_mode_e      mode_q
);

    // R1
    ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_ready && div_q != '0) |=> !pat_ready);

    // R1
    ready_every_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_ready && div_q == '0) |=> pat_ready);

    // R2
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pat_valid && pat_ready) |=> $stable(word_q));

    // R3
    underflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_ready && !pat_valid) |=> underflow);

    // R3
    underflow_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pat_ready && !pat_valid) |=> !underflow);

    // R4
    input_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & dir_q) == '0);

    // R7
    open_drain_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == DRV_OPEN_DRAIN) |-> (pin_val == '0));

endmodule

bind pgd_pin_driver pgd_pin_driver_chk #(
    .PINS  (PINS),
    .DIV_W (DIV_W)
) i_pgd_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pat_valid (pat_valid),
    .pat_ready (pat_ready),
    .underflow (underflow),
    .pin_oe    (pin_oe),
    .pin_val   (pin_val),
    .word_q    (word_q),
    .dir_q     (dir_q),
    .div_q     (div_q),
    .mode_q    (mode_q)
);

// File: tb/test_pgd_pin_driver.sv
`timescale 1ns/1ps
module test_pgd_pin_driver;

    localparam int PINS  = 16;
    localparam int DIV_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] cfg_div = '0;
    logic [PINS-1:0]  cfg_dir = '0;
    logic [PINS-1:0]  cfg_ovr_mask = '0;
    logic [PINS-1:0]  cfg_ovr_data = '0;
    logic             cfg_open_drain = 1'b0;
    logic             pat_valid = 1'b0;
    logic             pat_ready;
    logic [PINS-1:0]  pat_data = '0;
    logic [PINS-1:0]  pin_oe;
    logic [PINS-1:0]  pin_val;
    logic             underflow;

    int n_checks = 0;
    int n_fails  = 0;

    logic [PINS-1:0] exp_q[$];
    logic [PINS-1:0] last_word = '0;
    int  cyc = 0;
    int  last_hs = 0;
    bit  have_last = 0;
    bit  chk_gap = 0;
    int  exp_gap = 1;
    bit  pending = 0;
    int  uf_cnt = 0;

    always #5 clk = ~clk;

    pgd_pin_driver #(.PINS(PINS), .DIV_W(DIV_W)) i_pgd_pin_driver (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_div        (cfg_div),
        .cfg_dir        (cfg_dir),
        .cfg_ovr_mask   (cfg_ovr_mask),
        .cfg_ovr_data   (cfg_ovr_data),
        .cfg_open_drain (cfg_open_drain),
        .pat_valid      (pat_valid),
        .pat_ready      (pat_ready),
        .pat_data       (pat_data),
        .pin_oe         (pin_oe),
        .pin_val        (pin_val),
        .underflow      (underflow)
    );

    // Spec model: {oe, val} for a word under the current configuration.
    function automatic logic [2*PINS-1:0] model(logic [PINS-1:0] w);
        logic [PINS-1:0] src, oe, val;
        src = (cfg_ovr_mask & cfg_ovr_data) | (~cfg_ovr_mask & w);
        if (cfg_open_drain) begin
            oe  = ~src & ~cfg_dir;
            val = '0;
        end else begin
            oe  = ~cfg_dir;
            val = src & ~cfg_dir;
        end
        return {oe, val};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Monitor: compare outputs after each accepted word, check spacing, count underflows.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (underflow) uf_cnt <= uf_cnt + 1;
            if (pending) begin
                logic [PINS-1:0] w;
                w = exp_q.pop_front();
                last_word = w;
                check("R2/R5/R6 pins after accept", {pin_oe, pin_val}, model(w));
                pending = 0;
            end
            if (pat_valid && pat_ready) begin
                if (chk_gap && have_last)
                    check("R1 acceptance spacing", cyc - last_hs, exp_gap);
                last_hs   = cyc;
                have_last = 1;
                pending   = 1;
            end
        end
    end

    task automatic drive_step();
        @(posedge clk);
        #2;
    endtask

    task automatic send(logic [PINS-1:0] w);
        pat_data  = w;
        pat_valid = 1'b1;
        exp_q.push_back(w);
        forever begin
            @(negedge clk);
            if (pat_ready) break;
        end
        drive_step();
        pat_valid = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive_step();
    endtask

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        // R8: configuration ports busy during reset must not reach the pins
        cfg_dir        = '1;
        cfg_ovr_mask   = '1;
        cfg_ovr_data   = '1;
        cfg_open_drain = 1'b1;
        cfg_div        = 7;
        repeat (3) @(negedge clk);
        check("R8 reset oe", pin_oe, 16'hFFFF);
        check("R8 reset val", pin_val, 16'h0000);
        check("R8 reset underflow", underflow, 0);
        cfg_dir = '0; cfg_ovr_mask = '0; cfg_ovr_data = '0;
        cfg_open_drain = 1'b0; cfg_div = '0;
        drive_step();
        rst_n = 1'b1;
        idle(3);
        check("R8 after reset oe", pin_oe, 16'hFFFF);
        check("R8 after reset val", pin_val, 16'h0000);

        // R1/R6: divider 0, back-to-back words every cycle
        exp_gap = 1; have_last = 0; chk_gap = 1;
        send(16'hA5A5); send(16'h1234); send(16'hFFFF); send(16'h0001);
        idle(2);
        chk_gap = 0;

        // R1: divider 3, spacing 4
        cfg_div = 3;
        idle(10);
        exp_gap = 4; have_last = 0; chk_gap = 1;
        send(16'h5A5A); send(16'hC3C3); send(16'h0F0F);
        chk_gap = 0;
        // R2: word held between slots
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R2 held word", pin_val, 16'h0F0F);
        end
        drive_step();

        // R1: divider 5, spacing 6
        cfg_div = 5;
        idle(14);
        exp_gap = 6; have_last = 0; chk_gap = 1;
        send(16'h8001); send(16'h7FFE); send(16'h3333);
        chk_gap = 0;

        // R3: underflow with divider 2, 4 slots in 12 cycles
        cfg_div = 2;
        idle(10);
        uf_cnt = 0;
        idle(12);
        check("R3 underflow count", uf_cnt, 4);
        @(negedge clk);
        check("R3 held after underflow", pin_val, 16'h3333);
        drive_step();

        // R9: configuration reaches pins one edge later
        cfg_ovr_mask = 16'hFFFF;
        cfg_ovr_data = 16'h0000;
        @(negedge clk);
        check("R9 before capture", pin_val, 16'h3333);
        @(negedge clk);
        check("R9 after capture", pin_val, 16'h0000);
        drive_step();

        // R5: partial override
        cfg_ovr_mask = 16'hF0F0;
        cfg_ovr_data = 16'hA0A0;
        cfg_div = 0;
        idle(3);
        send(16'h0F0F);
        idle(1);
        check("R5 override mix", pin_val, 16'hAFAF);

        // R4: low byte as inputs
        cfg_ovr_mask = '0;
        cfg_dir = 16'h00FF;
        idle(3);
        send(16'hFFFF);
        idle(1);
        check("R4 input oe", pin_oe, 16'hFF00);
        check("R4 input val", pin_val, 16'hFF00);

        // R7: open drain
        cfg_dir = '0;
        cfg_open_drain = 1'b1;
        idle(3);
        send(16'h00FF);
        idle(1);
        check("R7 open drain oe", pin_oe, 16'hFF00);
        check("R7 open drain val", pin_val, 16'h0000);

        // R4/R7: inputs stay undriven with override and open drain
        cfg_dir = 16'h000F;
        cfg_ovr_mask = 16'h00FF;
        cfg_ovr_data = 16'h0000;
        idle(3);
        send(16'hFFFF);
        idle(1);
        check("R4 input under override+od", pin_oe, 16'h00F0);
        check("R7 od val", pin_val, 16'h0000);

        idle(4);
        check("R2 queue drained", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule